// File: doc/BRIEF.md
# Masked Event Flag Combiner

The block watches a wide vector of system event lines and records every rising edge in a sticky flag bit. The flags are split into groups of equal width. Each group has its own event mask and drives one combined interrupt event, which is high while any flag of that group is set and not masked. A second, independent set of mask words gates all flags at once into a single exception output. One set of flags feeds both mask sets, so an event can reach an interrupt line, the exception line, both, or neither.

Software reads the flags through a small word-addressed register port and clears them by writing ones. A flag never clears by itself: a combined event stays high until software has cleared every unmasked flag behind it. Since the flags are sticky, a second occurrence of an event before service cannot be told apart from the first, and the block does not try to detect it. The lowest event numbers of group 0 are reserved because they stand for the combined outputs themselves. Those flags never set. A selector outside this block routes the combined events to CPU interrupt lines.

Top module: `evc_event_combiner`

## Requirements
- R1: After reset all flags read 0, all event mask and exception mask words read all ones, and every combined event output and the exception output are 0.
- R2: A flag sets on the clock edge where its event input is 1 and was 0 at the previous edge. An input held high does not set the flag again after software has cleared it.
- R3: Writing to a flag word (word index 0 to 3 = group) clears each flag whose write-data bit is 1 and leaves the flags whose bit is 0 unchanged.
- R4: If an event rises in the same cycle as a software clear of its flag, the flag ends up set.
- R5: Flags 0 to 3 (group 0, bits 3:0) never set and always read 0, even when their event inputs rise and their mask bits are 0.
- R6: Combined event g is the OR over group g (flag index g*32 + bit) of flag AND NOT event-mask bit. It is registered and follows a flag or mask change one clock edge later.
- R7: An event mask bit of 1 blocks its flag from the combined event. Clearing the mask bit of an already set flag asserts the combined event, and setting it again deasserts the event. Event mask words sit at word indices 4 to 7.
- R8: The exception output is the OR over all groups of flag AND NOT exception-mask bit, with one edge of latency. It does not depend on the event masks. Exception mask words sit at word indices 8 to 11.
- R9: Reading word index 12 + g returns the flags of group g ANDed with the inverse of event mask g.
- R10: A combined event stays high until every unmasked flag in its group has been cleared.
- R11: Writes to the masked-status words (indices 12 to 15) change no flag and no mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 128 | System event lines |
| reg_addr_i | input | 4 | Register word index |
| reg_wen_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| comb_evt_o | output | 4 | Combined interrupt events, one per group |
| excep_o | output | 1 | Combined exception output |

## Verification
Single event pulses in different groups test that each flag lands in the right group word and the right combined output. Long-held levels separate edge capture from level capture. A pulse that coincides with a clear of the same bit tests the set-over-clear priority. Two unmasked flags in one group, cleared one at a time, show that the combined event holds until the last flag is cleared. Toggling event and exception masks around flags that are already set shows that the two mask sets act independently. Stimulus on the reserved low events and writes to the status words must leave all state unchanged.

// File: rtl/evc_pkg.sv
package evc_pkg;

    // Register kinds, selected by the upper two bits of the word index
    typedef enum logic [1:0] {
        REG_FLAG  = 2'd0,
        REG_EMASK = 2'd1,
        REG_XMASK = 2'd2,
        REG_STAT  = 2'd3
    } reg_kind_e;

    localparam int unsigned KIND_BITS = 2;

endpackage

// File: rtl/evc_flag_group.sv
module evc_flag_group #(
    parameter int unsigned GW   = 32,
    parameter int unsigned RSVD = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [GW-1:0] evt_i,
    input  logic [GW-1:0] flag_clr_i,
    input  logic          emask_we_i,
    input  logic          xmask_we_i,
    input  logic [GW-1:0] wdata_i,
    output logic [GW-1:0] flag_o,
    output logic [GW-1:0] emask_o,
    output logic [GW-1:0] xmask_o
);

    localparam logic [GW-1:0] KEEP = {GW{1'b1}} << RSVD;

    typedef struct packed {
        logic [GW-1:0] evt_prev;
        logic [GW-1:0] flag;
        logic [GW-1:0] emask;
        logic [GW-1:0] xmask;
    } grp_state_t;

    grp_state_t st_d, st_q;
    logic [GW-1:0] rise;

    always_comb begin
        st_d          = st_q;
        rise          = evt_i & ~st_q.evt_prev;
        st_d.evt_prev = evt_i;
        // a new edge wins over a clear in the same cycle
        st_d.flag     = ((st_q.flag & ~flag_clr_i) | rise) & KEEP;
        if (emask_we_i) begin
            st_d.emask = wdata_i;
        end
        if (xmask_we_i) begin
            st_d.xmask = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.evt_prev <= '0;
            st_q.flag     <= '0;
            st_q.emask    <= '1;
            st_q.xmask    <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o  = st_q.flag;
    assign emask_o = st_q.emask;
    assign xmask_o = st_q.xmask;

endmodule

// File: rtl/evc_combine.sv
module evc_combine #(
    parameter int unsigned NG = 4,
    parameter int unsigned GW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NG*GW-1:0] flag_i,
    input  logic [NG*GW-1:0] emask_i,
    input  logic [NG*GW-1:0] xmask_i,
    output logic [NG-1:0]    evt_o,
    output logic             exc_o
);

    typedef struct packed {
        logic [NG-1:0] evt;
        logic          exc;
    } out_state_t;

    out_state_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.exc = |(flag_i & ~xmask_i);
        for (int g = 0; g < NG; g++) begin
            out_d.evt[g] = |(flag_i[g*GW +: GW] & ~emask_i[g*GW +: GW]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign evt_o = out_q.evt;
    assign exc_o = out_q.exc;

endmodule

// File: rtl/evc_event_combiner.sv
module evc_event_combiner #(
    parameter int unsigned NUM_GROUPS  = 4,
    parameter int unsigned GROUP_WIDTH = 32,
    parameter int unsigned RSVD_LOW    = 4,
    localparam int unsigned NEVT       = NUM_GROUPS * GROUP_WIDTH,
    localparam int unsigned GRP_BITS   = $clog2(NUM_GROUPS),
    localparam int unsigned AW         = evc_pkg::KIND_BITS + GRP_BITS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NEVT-1:0]        evt_i,
    input  logic [AW-1:0]          reg_addr_i,
    input  logic                   reg_wen_i,
    input  logic [GROUP_WIDTH-1:0] reg_wdata_i,
    output logic [GROUP_WIDTH-1:0] reg_rdata_o,
    output logic [NUM_GROUPS-1:0]  comb_evt_o,
    output logic                   excep_o
);
    import evc_pkg::*;

    reg_kind_e            kind;
    logic [GRP_BITS-1:0]  grp;
    logic [NEVT-1:0]      flag_all;
    logic [NEVT-1:0]      emask_all;
    logic [NEVT-1:0]      xmask_all;

    assign kind = reg_kind_e'(reg_addr_i[AW-1 -: KIND_BITS]);
    assign grp  = reg_addr_i[GRP_BITS-1:0];

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic                   sel;
        logic [GROUP_WIDTH-1:0] clr;

        assign sel = reg_wen_i && (grp == GRP_BITS'(g));
        assign clr = (sel && kind == REG_FLAG) ? reg_wdata_i : '0;

        evc_flag_group #(
            .GW   (GROUP_WIDTH),
            .RSVD ((g == 0) ? RSVD_LOW : 0)
        ) grp_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt_i      (evt_i[g*GROUP_WIDTH +: GROUP_WIDTH]),
            .flag_clr_i (clr),
            .emask_we_i (sel && kind == REG_EMASK),
            .xmask_we_i (sel && kind == REG_XMASK),
            .wdata_i    (reg_wdata_i),
            .flag_o     (flag_all[g*GROUP_WIDTH +: GROUP_WIDTH]),
            .emask_o    (emask_all[g*GROUP_WIDTH +: GROUP_WIDTH]),
            .xmask_o    (xmask_all[g*GROUP_WIDTH +: GROUP_WIDTH])
        );
    end

    always_comb begin
        reg_rdata_o = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (grp == GRP_BITS'(g)) begin
                unique case (kind)
                    REG_FLAG:  reg_rdata_o = flag_all[g*GROUP_WIDTH +: GROUP_WIDTH];
                    REG_EMASK: reg_rdata_o = emask_all[g*GROUP_WIDTH +: GROUP_WIDTH];
                    REG_XMASK: reg_rdata_o = xmask_all[g*GROUP_WIDTH +: GROUP_WIDTH];
                    REG_STAT:  reg_rdata_o = flag_all[g*GROUP_WIDTH +: GROUP_WIDTH]
                                           & ~emask_all[g*GROUP_WIDTH +: GROUP_WIDTH];
                    default:   reg_rdata_o = '0;
                endcase
            end
        end
    end

    evc_combine #(
        .NG (NUM_GROUPS),
        .GW (GROUP_WIDTH)
    ) comb_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .flag_i  (flag_all),
        .emask_i (emask_all),
        .xmask_i (xmask_all),
        .evt_o   (comb_evt_o),
        .exc_o   (excep_o)
    );

endmodule

// File: rtl/evc_event_combiner_chk.sv
module evc_event_combiner_chk #(
    parameter int unsigned NUM_GROUPS  = 4,
    parameter int unsigned GROUP_WIDTH = 32,
    parameter int unsigned RSVD_LOW    = 4,
    localparam int unsigned NEVT       = NUM_GROUPS * GROUP_WIDTH
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NEVT-1:0]       evt_i,
    input logic [NEVT-1:0]       flag_all,
    input logic [NEVT-1:0]       emask_all,
    input logic [NEVT-1:0]       xmask_all,
    input logic [NUM_GROUPS-1:0] comb_evt_o,
    input logic                  excep_o
);

    localparam logic [NEVT-1:0] VALID = {NEVT{1'b1}} << RSVD_LOW;

    logic [1:0]            live_q;
    logic [NUM_GROUPS-1:0] grp_or;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
        end else if (live_q != 2'd3) begin
            live_q <= live_q + 2'd1;
        end
    end

    always_comb begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
            grp_or[g] = |(flag_all[g*GROUP_WIDTH +: GROUP_WIDTH]
                        & ~emask_all[g*GROUP_WIDTH +: GROUP_WIDTH]);
        end
    end

    // R2 R4
    flag_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q >= 2'd2) |-> ((($past(evt_i) & ~$past(evt_i, 2)) & VALID & ~flag_all) == '0));

    // R5
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_all & ~VALID) == '0);

    // R6
    comb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q >= 2'd1) |-> (comb_evt_o == $past(grp_or)));

    // R8
    excep_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q >= 2'd1) |-> (excep_o == $past(|(flag_all & ~xmask_all))));

    // R1
    reset_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q == 2'd0) |-> (comb_evt_o == '0 && !excep_o));

endmodule

bind evc_event_combiner evc_event_combiner_chk #(
    .NUM_GROUPS  (NUM_GROUPS),
    .GROUP_WIDTH (GROUP_WIDTH),
    .RSVD_LOW    (RSVD_LOW)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .flag_all   (flag_all),
    .emask_all  (emask_all),
    .xmask_all  (xmask_all),
    .comb_evt_o (comb_evt_o),
    .excep_o    (excep_o)
);

// File: tb/evc_event_combiner_tb_top.sv
`timescale 1ns/1ps
module evc_event_combiner_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] evt = '0;
    logic [3:0]   addr = '0;
    logic         wen = 1'b0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [3:0]   cevt;
    logic         exc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    evc_event_combiner dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .reg_addr_i  (addr),
        .reg_wen_i   (wen),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .comb_evt_o  (cevt),
        .excep_o     (exc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        addr = 4'(idx); wdata = d; wen = 1'b1;
        @(negedge clk);
        wen = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [31:0] d);
        addr = 4'(idx);
        #0.5;
        d = rdata;
    endtask

    task automatic pulse(input int bitno);
        @(negedge clk); evt[bitno] = 1'b1;
        @(negedge clk); evt[bitno] = 1'b0;
    endtask

    task automatic cleanup();
        evt = '0;
        for (int g = 0; g < 4; g++) begin
            wr(g, 32'hFFFF_FFFF);
            wr(4 + g, 32'hFFFF_FFFF);
            wr(8 + g, 32'hFFFF_FFFF);
        end
        @(negedge clk); @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int g = 0; g < 4; g++) begin
            rd(g, v);     check("R1 flag", v, 32'h0);
            rd(4 + g, v); check("R1 emask", v, 32'hFFFF_FFFF);
            rd(8 + g, v); check("R1 xmask", v, 32'hFFFF_FFFF);
        end
        check("R1 comb", {28'h0, cevt}, 32'h0);
        check("R1 exc", {31'h0, exc}, 32'h0);
    endtask

    task automatic t_set_clear();
        logic [31:0] v;
        @(negedge clk); evt[40] = 1'b1;
        @(negedge clk);
        rd(1, v); check("R2 rise sets", v, 32'h100);
        wr(1, 32'h100);
        @(negedge clk);
        rd(1, v); check("R2 held level no reset", v, 32'h0);
        evt[40] = 1'b0;
        pulse(41); pulse(45);
        wr(1, 32'h0);
        rd(1, v); check("R3 zero write keeps", v, 32'h2200);
        wr(1, 32'h200);
        rd(1, v); check("R3 w1c selective", v, 32'h2000);
        cleanup();
    endtask

    task automatic t_priority();
        logic [31:0] v;
        @(negedge clk);
        evt[70] = 1'b1; addr = 4'd2; wdata = 32'h40; wen = 1'b1;
        @(negedge clk);
        wen = 1'b0; evt[70] = 1'b0;
        rd(2, v); check("R4 set wins", v, 32'h40);
        cleanup();
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        wr(4, 32'h0);
        @(negedge clk); evt[3:0] = 4'hF;
        @(negedge clk); evt[3:0] = 4'h0;
        @(negedge clk); @(negedge clk);
        rd(0, v); check("R5 low flags zero", v, 32'h0);
        check("R5 comb0 quiet", {31'h0, cevt[0]}, 32'h0);
        pulse(4);
        rd(0, v); check("R5 bit4 sets", v, 32'h10);
        cleanup();
    endtask

    task automatic t_combine();
        logic [31:0] v;
        wr(5, 32'hFFFF_FEFF);
        pulse(40);
        check("R6 latency before", {28'h0, cevt}, 32'h0);
        @(negedge clk);
        check("R6 comb1 asserts", {28'h0, cevt}, 32'h2);
        wr(5, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R7 mask blocks", {28'h0, cevt}, 32'h0);
        wr(5, 32'hFFFF_FEFF);
        @(negedge clk);
        check("R7 unmask set flag", {28'h0, cevt}, 32'h2);
        wr(7, 32'hFFFF_FFF5);
        pulse(97); pulse(99);
        @(negedge clk);
        check("R6 comb3", {28'h0, cevt}, 32'hA);
        wr(3, 32'h2);
        @(negedge clk);
        check("R10 holds", {28'h0, cevt}, 32'hA);
        wr(3, 32'h8);
        @(negedge clk);
        check("R10 releases", {28'h0, cevt}, 32'h2);
        cleanup();
    endtask

    task automatic t_exception();
        wr(10, 32'hFFFF_FFDF);
        pulse(69);
        @(negedge clk);
        check("R8 exc asserts", {31'h0, exc}, 32'h1);
        check("R8 comb unaffected", {28'h0, cevt}, 32'h0);
        pulse(100);
        wr(2, 32'h20);
        @(negedge clk);
        check("R8 exc drops", {31'h0, exc}, 32'h0);
        cleanup();
    endtask

    task automatic t_status();
        logic [31:0] v;
        wr(6, 32'hFFFF_FFFB);
        pulse(66); pulse(67);
        rd(14, v); check("R9 status", v, 32'h4);
        wr(14, 32'hFFFF_FFFF);
        rd(2, v);  check("R11 flags kept", v, 32'hC);
        rd(6, v);  check("R11 emask kept", v, 32'hFFFF_FFFB);
        rd(10, v); check("R11 xmask kept", v, 32'hFFFF_FFFF);
        cleanup();
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_clear();
        t_priority();
        t_reserved();
        t_combine();
        t_exception();
        t_status();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule